// File: doc/BRIEF.md
# Register Status Tag Table

This block sits at the issue stage of a dynamically scheduled core. Every architectural register holds a value and a small producer tag. A nonzero tag names the reservation station that will produce the register's next value. Each cycle the block resolves two source-register lookups for the instruction being issued. If no producer is pending, a lookup returns the register value. Otherwise it returns the producer tag, so that the station can wait for that result.

When an instruction with a destination is issued, its station tag is written against the destination register. A later writer to the same register replaces the tag. Two writers of one register therefore refer to different stations, and write-after-write ordering needs no free list. Results come back as a tag and value pair on a shared result bus. A register takes the value, and drops its tag, only when its stored tag equals the broadcast tag. A register that a younger instruction has claimed is left alone.

Top module: `reg_tag_table`

## Requirements
- R1: A synchronous active-low reset clears every register to tag 0 and value 0. After reset, a lookup of any register returns ready=1 and value 0.
- R2: When the looked-up register has tag 0, the lookup returns ready=1, its stored value and tag 0. When the tag is nonzero and no matching broadcast is present, the lookup returns ready=0, the stored tag and value 0.
- R3: When `dst_valid` is high at a clock edge, `iss_tag` becomes the tag of register `dst` from the next cycle on. This replaces any tag the register already held.
- R4: A broadcast (`cdb_valid`=1) whose nonzero tag equals a register's stored tag writes `cdb_value` into that register and sets its tag to 0 at the next edge.
- R5: A broadcast whose tag differs from a register's stored tag leaves that register's tag and value unchanged. A broadcast with tag 0 changes nothing.
- R6: When an issue to register r and a broadcast matching r's tag fall in the same cycle, r ends up holding the new issue tag.
- R7: When a looked-up register's pending tag equals the tag of the broadcast in the same cycle, the lookup returns ready=1, the broadcast value and tag 0.
- R8: A lookup sees the table as it was before the same cycle's issue. A source equal to the destination being issued therefore returns the earlier mapping.
- R9: With `dst_valid` low, no tag changes, whatever `dst` and `iss_tag` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a | input | 4 | First source register index |
| src_b | input | 4 | Second source register index |
| dst_valid | input | 1 | Issue with a destination this cycle |
| dst | input | 4 | Destination register index |
| iss_tag | input | 4 | Station tag of the issued instruction (nonzero) |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | 4 | Tag of the broadcasting station |
| cdb_value | input | 32 | Broadcast result |
| a_ready | output | 1 | First source value available |
| a_value | output | 32 | First source value (0 when not ready) |
| a_tag | output | 4 | First source pending tag (0 when ready) |
| b_ready | output | 1 | Second source value available |
| b_value | output | 32 | Second source value (0 when not ready) |
| b_tag | output | 4 | Second source pending tag (0 when ready) |

## Verification
An issue and a result broadcast can fall in the same cycle, and they can touch the same register. The bench provokes this on purpose. It issues a new tag to a register whose old producer broadcasts in that cycle, and looks that register up as a source in the same cycle. It then expects the bypassed broadcast value from the lookup, and the new tag one cycle later. Random traffic picks its broadcast tags mostly from tags that are pending in the table. This repeats the collision many times, and a bench model checks each lookup.

// File: rtl/rtt_pkg.sv
// Package rtt_pkg: shared sizing defaults for the register status tag table.
// Assumes: tag value 0 is reserved to mean "no pending producer".
package rtt_pkg;
    localparam int RTT_REGS   = 16;
    localparam int RTT_DATA_W = 32;
    localparam int RTT_TAG_W  = 4;
    localparam int RTT_IDX_W  = $clog2(RTT_REGS);
endpackage

// File: rtl/rtt_entry.sv
// Module rtt_entry: one architectural register with its producer tag.
// An issue to this register loads a new tag. A broadcast whose tag matches
// the stored tag writes the value and clears the tag. The issue wins when
// both happen in the same cycle.
// Assumes: tags issued with dst_valid are nonzero.
module rtt_entry #(
    parameter int IDX    = 0,
    parameter int IDX_W  = rtt_pkg::RTT_IDX_W,
    parameter int DATA_W = rtt_pkg::RTT_DATA_W,
    parameter int TAG_W  = rtt_pkg::RTT_TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dst_valid,
    input  logic [IDX_W-1:0]  dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic [TAG_W-1:0]  tag_q,
    output logic [DATA_W-1:0] val_q
);
    logic issue_hit;
    logic cdb_hit;

    // Decode whether this cycle's issue or broadcast concerns this register.
    always_comb begin
        issue_hit = dst_valid && (dst == IDX_W'(IDX));
        cdb_hit   = cdb_valid && (cdb_tag != '0) && (tag_q == cdb_tag);
    end

    // Tag update: reset clears, issue overrides, matching broadcast clears.
    always_ff @(posedge clk) begin
        if (!rst_n)         tag_q <= '0;
        else if (issue_hit) tag_q <= iss_tag;
        else if (cdb_hit)   tag_q <= '0;
    end

    // Value update: take the broadcast result when the tag matches.
    always_ff @(posedge clk) begin
        if (!rst_n)       val_q <= '0;
        else if (cdb_hit) val_q <= cdb_value;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (tag_q == '0 && val_q == '0)); // R1

    AST_ISSUE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        issue_hit |=> tag_q == $past(iss_tag)); // R3

    AST_CDB_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_hit && !issue_hit) |=> (tag_q == '0 && val_q == $past(cdb_value))); // R4

    AST_MISMATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cdb_hit && !issue_hit) |=> ($stable(tag_q) && $stable(val_q))); // R5

    AST_ISSUE_BEATS_CDB: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_hit && issue_hit) |=> tag_q == $past(iss_tag)); // R6
endmodule

// File: rtl/rtt_lookup.sv
// Module rtt_lookup: resolves one source operand from a selected register.
// It returns the value when no producer is pending, or when the pending
// producer broadcasts in this cycle. Otherwise it returns the pending tag.
// Assumes: stored_tag and stored_val come from the same register.
module rtt_lookup #(
    parameter int DATA_W = rtt_pkg::RTT_DATA_W,
    parameter int TAG_W  = rtt_pkg::RTT_TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  stored_tag,
    input  logic [DATA_W-1:0] stored_val,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic              rdy,
    output logic [DATA_W-1:0] val_o,
    output logic [TAG_W-1:0]  tag_o
);
    logic bypass;

    // Select among stored value, bypassed broadcast and pending tag.
    always_comb begin
        bypass = cdb_valid && (stored_tag != '0) && (cdb_tag == stored_tag);
        if (stored_tag == '0) begin
            rdy = 1'b1; val_o = stored_val; tag_o = '0;
        end else if (bypass) begin
            rdy = 1'b1; val_o = cdb_value;  tag_o = '0;
        end else begin
            rdy = 1'b0; val_o = '0;         tag_o = stored_tag;
        end
    end

    AST_PENDING_HAS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> (tag_o == stored_tag && stored_tag != '0 && val_o == '0)); // R2
endmodule

// File: rtl/reg_tag_table.sv
// Module reg_tag_table: a rename table for architectural registers.
// Each register holds a value and the tag of its pending producer station.
// There are two combinational source lookups, one destination tag write per
// cycle, and one result broadcast input.
// Assumes: one issue per cycle; issued tags are nonzero.
module reg_tag_table
    import rtt_pkg::*;
#(
    parameter int NUM_REGS = RTT_REGS,
    parameter int DATA_W   = RTT_DATA_W,
    parameter int TAG_W    = RTT_TAG_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_REGS)-1:0] src_a,
    input  logic [$clog2(NUM_REGS)-1:0] src_b,
    input  logic                        dst_valid,
    input  logic [$clog2(NUM_REGS)-1:0] dst,
    input  logic [TAG_W-1:0]            iss_tag,
    input  logic                        cdb_valid,
    input  logic [TAG_W-1:0]            cdb_tag,
    input  logic [DATA_W-1:0]           cdb_value,
    output logic                        a_ready,
    output logic [DATA_W-1:0]           a_value,
    output logic [TAG_W-1:0]            a_tag,
    output logic                        b_ready,
    output logic [DATA_W-1:0]           b_value,
    output logic [TAG_W-1:0]            b_tag
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [TAG_W-1:0]  tag_arr [NUM_REGS];
    logic [DATA_W-1:0] val_arr [NUM_REGS];
    logic [TAG_W-1:0]  a_st_tag, b_st_tag;
    logic [DATA_W-1:0] a_st_val, b_st_val;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        rtt_entry #(.IDX(g), .IDX_W(IDX_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .dst_valid (dst_valid),
            .dst       (dst),
            .iss_tag   (iss_tag),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_value (cdb_value),
            .tag_q     (tag_arr[g]),
            .val_q     (val_arr[g])
        );
    end

    // Read the registered state of both source registers.
    always_comb begin
        a_st_tag = tag_arr[src_a];
        a_st_val = val_arr[src_a];
        b_st_tag = tag_arr[src_b];
        b_st_val = val_arr[src_b];
    end

    rtt_lookup #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_look_a (
        .clk (clk), .rst_n (rst_n),
        .stored_tag (a_st_tag), .stored_val (a_st_val),
        .cdb_valid (cdb_valid), .cdb_tag (cdb_tag), .cdb_value (cdb_value),
        .rdy (a_ready), .val_o (a_value), .tag_o (a_tag)
    );

    rtt_lookup #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_look_b (
        .clk (clk), .rst_n (rst_n),
        .stored_tag (b_st_tag), .stored_val (b_st_val),
        .cdb_valid (cdb_valid), .cdb_tag (cdb_tag), .cdb_value (cdb_value),
        .rdy (b_ready), .val_o (b_value), .tag_o (b_tag)
    );

    AST_NO_ZERO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid |-> iss_tag != '0); // R3

    AST_IDLE_KEEPS_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dst_valid && !cdb_valid) |=> ($stable(a_st_tag) || $past(src_a) != src_a)); // R9
endmodule

// File: tb/reg_tag_table_bench.sv
module reg_tag_table_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_a = '0, src_b = '0, dst = '0, iss_tag = '0, cdb_tag = '0;
    logic        dst_valid = 1'b0, cdb_valid = 1'b0;
    logic [31:0] cdb_value = '0;
    logic        a_ready, b_ready;
    logic [31:0] a_value, b_value;
    logic [3:0]  a_tag, b_tag;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [3:0]  m_tag [NR];
    logic [31:0] m_val [NR];

    reg_tag_table u_reg_tag_table (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .dst_valid(dst_valid), .dst(dst), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .a_ready(a_ready), .a_value(a_value), .a_tag(a_tag),
        .b_ready(b_ready), .b_value(b_value), .b_tag(b_tag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected lookup result from the bench model and the current broadcast.
    function automatic logic [36:0] exp_look(input int r);
        if (m_tag[r] == 4'd0)                         return {1'b1, m_val[r], 4'd0};
        else if (cdb_valid && cdb_tag == m_tag[r])    return {1'b1, cdb_value, 4'd0};
        else                                          return {1'b0, 32'd0, m_tag[r]};
    endfunction

    task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual rdy=%0b val=%h tag=%0d expected rdy=%0b val=%h tag=%0d",
                     req, act[36], act[35:4], act[3:0], exp[36], exp[35:4], exp[3:0]);
        end
    endtask

    // Check both lookups against the model; label the check by the case it covers.
    task automatic check_lookups(input string req);
        check(req, {a_ready, a_value, a_tag}, exp_look(int'(src_a)));
        check(req, {b_ready, b_value, b_tag}, exp_look(int'(src_b)));
    endtask

    // Advance the model by one edge, following R3 to R6 and R9.
    task automatic model_step();
        logic [3:0] ot [NR];
        for (int r = 0; r < NR; r++) ot[r] = m_tag[r];
        for (int r = 0; r < NR; r++) begin
            if (cdb_valid && cdb_tag != 0 && ot[r] == cdb_tag) begin
                m_val[r] = cdb_value;
                m_tag[r] = 4'd0;
            end
            if (dst_valid && int'(dst) == r) m_tag[r] = iss_tag;
        end
    endtask

    // One cycle: inputs already set after a falling edge; check, clock, update.
    task automatic cycle(input string req);
        #1;
        check_lookups(req);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        dst_valid = 0; cdb_valid = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) begin m_tag[r] = 0; m_val[r] = 0; end
        void'($urandom(32'h5A17));
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        idle();
        // R1: every register reads ready with value zero after reset.
        for (int r = 0; r < NR; r += 2) begin
            src_a = 4'(r); src_b = 4'(r + 1);
            cycle("R1");
        end
        // R3: issue r2 tag 5, then overwrite with tag 9.
        dst_valid = 1; dst = 2; iss_tag = 5; src_a = 2; src_b = 0;
        cycle("R8");
        iss_tag = 9;
        cycle("R2");
        idle();
        cycle("R3");
        // R5: stale tag 5 broadcast must not touch r2.
        cdb_valid = 1; cdb_tag = 5; cdb_value = 32'h1111_2222;
        cycle("R5");
        cdb_valid = 1; cdb_tag = 0; cdb_value = 32'h3333_4444;
        cycle("R5");
        idle();
        cycle("R5");
        // R7 then R4: matching broadcast bypasses, then retires into r2.
        cdb_valid = 1; cdb_tag = 9; cdb_value = 32'hDEAD_BEEF;
        cycle("R7");
        idle();
        cycle("R4");
        // R6: issue and matching broadcast on r4 in one cycle; source sees bypass (R8).
        dst_valid = 1; dst = 4; iss_tag = 3; src_a = 4; src_b = 2;
        cycle("R3");
        dst_valid = 1; dst = 4; iss_tag = 6; cdb_valid = 1; cdb_tag = 3; cdb_value = 32'hCAFE_0004;
        cycle("R7");
        idle();
        cycle("R6");
        // R9: dst_valid low leaves r5 untouched.
        dst = 5; iss_tag = 7; src_a = 5; src_b = 4;
        cycle("R9");
        cycle("R9");
        // Random traffic.
        for (int i = 0; i < 4000; i++) begin
            src_a = 4'($urandom_range(0, NR - 1));
            src_b = 4'($urandom_range(0, NR - 1));
            dst_valid = ($urandom_range(0, 99) < 50);
            dst = 4'($urandom_range(0, NR - 1));
            iss_tag = 4'($urandom_range(1, 15));
            cdb_valid = ($urandom_range(0, 99) < 60);
            if ($urandom_range(0, 99) < 75) cdb_tag = m_tag[$urandom_range(0, NR - 1)];
            else cdb_tag = 4'($urandom_range(0, 15));
            cdb_value = $urandom;
            cycle("R2");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule